// File: doc/BRIEF.md
# Fast-Cycle Window Address Decoder

This block tells the bus controller whether the cycle now on the bus falls inside one of the address windows that software has marked for short (fast) timing. There are two memory windows and one I/O window. Each window holds a programmed base value and a mask. A mask bit of one makes the matching address bit take part in the compare. A mask bit of zero makes that bit a don't-care. The memory windows look at address bits 23 down to 12 in nibble groups. The I/O window looks at I/O address bits 9 down to 2.

The window settings live in byte-wide configuration registers reached through an index/data pair. A write strobe latches a register number from the data bus. Later data writes go to that register, and the read bus always shows it. A global enable bit, clear after reset, holds every hit output low until software has set the windows up. The hit flags are combinational from the address, the cycle-type strobes and the stored configuration. The bus state machine that shortens the cycle sits outside this block.

Top module: `fastdec`

## Requirements
- R1: After reset the registers read: index 0 (control) 0x00; indices 1 and 4 (window base bits 23..16) 0x00; indices 2 and 5 (window mask bits 23..16) 0xFF; indices 3 and 6 (packed low register) 0xF0; index 7 (I/O base) 0x00; index 8 (I/O mask) 0xFF.
- R2: A cycle with `cfgIdxWr` high stores `cfgWdata[3:0]` as the current index. A cycle with `cfgDataWr` high writes `cfgWdata` into the register at the current index, taking effect at that clock edge. `cfgRdata` shows the register at the current index combinationally.
- R3: Indices 9 to 15 read as 0x00, and writes to them have no effect. Control bits 7..1 always read as zero.
- R4: Control bit 0 is the global enable. While it is 0, `fastHit` and all `winHit` bits are 0.
- R5: A window matches when every address bit whose mask bit is 1 equals its base bit. Address bits whose mask bit is 0 are ignored.
- R6: Memory window w (w = 0, 1) compares `memAddr[23:12]`. Its 12-bit base is {register 1+3w, bits 3..0 of register 3+3w}. Its 12-bit mask is {register 2+3w, bits 7..4 of register 3+3w}. `winHit[w]` reports it.
- R7: The I/O window compares `ioAddr[9:2]` with register 7 as base and register 8 as mask. `winHit[2]` reports it.
- R8: Memory window hits need `memCycle` high, and the I/O hit needs `ioCycle` high.
- R9: `fastHit` is the OR of the `winHit` bits, in the same cycle as the address.
- R10: With reset configuration and the enable set, each memory window hits only for `memAddr[23:12]` equal to zero, and the I/O window hits only for `ioAddr[9:2]` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgIdxWr | input | 1 | Latch register index from cfgWdata[3:0] |
| cfgDataWr | input | 1 | Write cfgWdata into the indexed register |
| cfgWdata | input | 8 | Configuration write bus |
| cfgRdata | output | 8 | Contents of the indexed register |
| memCycle | input | 1 | Current cycle is a memory cycle |
| memAddr | input | 24 | Memory address |
| ioCycle | input | 1 | Current cycle is an I/O cycle |
| ioAddr | input | 10 | I/O address |
| winHit | output | 3 | Per-window hit: bits 1..0 memory, bit 2 I/O |
| fastHit | output | 1 | Any window hit |

## Verification
The hit outputs depend on no clock. They are due in the same cycle as the address and strobes, so the bench checks them 1 ns after it drives new values on a falling edge. Register contents change at the rising edge of the data-write cycle. The read data follows the index one rising edge after the index write. For that reason each read-back check and each post-write hit check is queued only on the falling edge after that rising edge. The expected values come from a shadow register copy and a bit-by-bit mask compare written from the requirements.

// File: rtl/fastdec_pkg.sv
package fastdec_pkg;
  localparam int DATA_W      = 8;
  localparam int IDX_W       = 4;
  localparam int NUM_MEM_WIN = 2;
  localparam int NUM_WIN     = NUM_MEM_WIN + 1;
  localparam int REGS_PER_MW = 3;
  localparam int IO_IDX      = 1 + REGS_PER_MW * NUM_MEM_WIN;
  localparam int NUM_REG     = IO_IDX + 2;

  typedef struct packed {
    logic [NUM_REG-1:0] wrSel;
    logic [DATA_W-1:0]  wrData;
    logic [IDX_W-1:0]   rdIdx;
  } cfgStrobe_t;

  function automatic logic [DATA_W-1:0] resetValue(int i);
    if (i == 0)            return 8'h00;
    else if (i == IO_IDX)  return 8'h00;
    else if (i > IO_IDX)   return 8'hFF;
    else case ((i - 1) % REGS_PER_MW)
      0:       return 8'h00;
      1:       return 8'hFF;
      default: return 8'hF0;
    endcase
  endfunction
endpackage

// File: rtl/fastdec_ctrl.sv
module fastdec_ctrl
  import fastdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgIdxWr,
  input  logic              cfgDataWr,
  input  logic [DATA_W-1:0] cfgWdata,
  output cfgStrobe_t        strb
);
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN)         idxQ <= '0;
    else if (cfgIdxWr) idxQ <= cfgWdata[IDX_W-1:0];
  end

  always_comb begin
    strb.wrData = cfgWdata;
    strb.rdIdx  = idxQ;
    for (int i = 0; i < NUM_REG; i++)
      strb.wrSel[i] = cfgDataWr && (idxQ == IDX_W'(i));
  end
endmodule

// File: rtl/fastdec_dp.sv
module fastdec_dp
  import fastdec_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  output logic [DATA_W-1:0]  cfgRdata,
  input  logic               memCycle,
  input  logic [MEM_AW-1:0]  memAddr,
  input  logic               ioCycle,
  input  logic [IO_AW-1:0]   ioAddr,
  output logic [NUM_WIN-1:0] winHit
);
  localparam int MEM_LO = MEM_AW - 12;
  localparam int IO_LO  = IO_AW - 8;

  logic [DATA_W-1:0] cfgReg [NUM_REG];
  logic              globalEn;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REG; i++) begin
      if (!rstN)
        cfgReg[i] <= resetValue(i);
      else if (strb.wrSel[i])
        cfgReg[i] <= (i == 0) ? {{(DATA_W-1){1'b0}}, strb.wrData[0]} : strb.wrData;
    end
  end

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_REG; i++)
      if (strb.rdIdx == IDX_W'(i)) cfgRdata = cfgReg[i];
  end

  assign globalEn = cfgReg[0][0];

  genvar w;
  generate
    for (w = 0; w < NUM_MEM_WIN; w++) begin : gMemWin
      logic [11:0] baseV, maskV;
      logic        match;
      assign baseV  = {cfgReg[1 + REGS_PER_MW*w], cfgReg[3 + REGS_PER_MW*w][3:0]};
      assign maskV  = {cfgReg[2 + REGS_PER_MW*w], cfgReg[3 + REGS_PER_MW*w][7:4]};
      assign match  = ((memAddr[MEM_AW-1:MEM_LO] ^ baseV) & maskV) == 12'h000;
      assign winHit[w] = globalEn & memCycle & match;
    end
  endgenerate

  logic ioMatch;
  assign ioMatch = ((ioAddr[IO_AW-1:IO_LO] ^ cfgReg[IO_IDX]) & cfgReg[IO_IDX+1]) == 8'h00;
  assign winHit[NUM_WIN-1] = globalEn & ioCycle & ioMatch;

  logic unusedAddrBits;
  assign unusedAddrBits = ^{memAddr[MEM_LO-1:0], ioAddr[IO_LO-1:0]};
endmodule

// File: rtl/fastdec.sv
module fastdec
  import fastdec_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgIdxWr,
  input  logic               cfgDataWr,
  input  logic [DATA_W-1:0]  cfgWdata,
  output logic [DATA_W-1:0]  cfgRdata,
  input  logic               memCycle,
  input  logic [MEM_AW-1:0]  memAddr,
  input  logic               ioCycle,
  input  logic [IO_AW-1:0]   ioAddr,
  output logic [NUM_WIN-1:0] winHit,
  output logic               fastHit
);
  cfgStrobe_t strb;

  fastdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgIdxWr(cfgIdxWr), .cfgDataWr(cfgDataWr),
    .cfgWdata(cfgWdata), .strb(strb)
  );

  fastdec_dp #(.MEM_AW(MEM_AW), .IO_AW(IO_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgRdata(cfgRdata),
    .memCycle(memCycle), .memAddr(memAddr), .ioCycle(ioCycle),
    .ioAddr(ioAddr), .winHit(winHit)
  );

  assign fastHit = |winHit;
endmodule

// File: rtl/fastdec_chk.sv
module fastdec_chk
  import fastdec_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgIdxWr,
  input logic               cfgDataWr,
  input logic [DATA_W-1:0]  cfgWdata,
  input logic [DATA_W-1:0]  cfgRdata,
  input logic               memCycle,
  input logic               ioCycle,
  input logic [NUM_WIN-1:0] winHit,
  input logic               fastHit
);
  logic [IDX_W-1:0] idxSeen;
  logic             wroteAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxSeen  <= '0;
      wroteAny <= 1'b0;
    end else begin
      if (cfgIdxWr)  idxSeen  <= cfgWdata[IDX_W-1:0];
      if (cfgDataWr) wroteAny <= 1'b1;
    end
  end

  // R8
  a_r8_mem_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (|winHit[NUM_MEM_WIN-1:0]) |-> memCycle);
  // R8
  a_r8_io_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    winHit[NUM_WIN-1] |-> ioCycle);
  // R9
  a_r9_idle_bus_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (!memCycle && !ioCycle) |-> !fastHit);
  // R4: enable is clear until some register write happens
  a_r4_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !wroteAny |-> !fastHit);
  // R2
  a_r2_write_reads_back: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataWr && !cfgIdxWr && idxSeen != '0 && idxSeen < IDX_W'(NUM_REG))
      |=> cfgRdata == $past(cfgWdata));
  // R3
  a_r3_unused_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (idxSeen >= IDX_W'(NUM_REG)) |-> cfgRdata == '0);
  // R3
  a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (idxSeen == '0) |-> cfgRdata[DATA_W-1:1] == '0);
endmodule

bind fastdec fastdec_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgIdxWr(cfgIdxWr), .cfgDataWr(cfgDataWr),
  .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .memCycle(memCycle),
  .ioCycle(ioCycle), .winHit(winHit), .fastHit(fastHit)
);

// File: tb/sim_fastdec.sv
`timescale 1ns/1ps
module sim_fastdec;
  import fastdec_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgIdxWr = 1'b0, cfgDataWr = 1'b0;
  logic [7:0]  cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic        memCycle = 1'b0, ioCycle = 1'b0;
  logic [23:0] memAddr = '0;
  logic [9:0]  ioAddr = '0;
  logic [2:0]  winHit;
  logic        fastHit;

  always #2.5 clk = ~clk;

  fastdec u0 (.*);

  typedef struct {
    bit         rdChk;
    logic [7:0] expRd;
    logic [2:0] expWin;
    logic       expFast;
    string      tag;
  } item_t;

  item_t      sbq[$];
  int         checks = 0, failures = 0;
  bit         finished = 0;
  logic [7:0] sh [16];

  function automatic bit maskMatch(logic [11:0] a, logic [11:0] b, logic [11:0] m);
    for (int k = 0; k < 12; k++)
      if (m[k] && (a[k] !== b[k])) return 0;
    return 1;
  endfunction

  function automatic logic [2:0] modelWin(logic [23:0] ma, logic [9:0] ia, logic mc, logic ic);
    logic [2:0] r;
    r = '0;
    if (sh[0][0]) begin
      for (int w = 0; w < 2; w++)
        r[w] = mc && maskMatch(ma[23:12], {sh[1+3*w], sh[3+3*w][3:0]},
                               {sh[2+3*w], sh[3+3*w][7:4]});
      r[2] = ic && maskMatch({4'h0, ia[9:2]}, {4'h0, sh[7]}, {4'h0, sh[8]});
    end
    return r;
  endfunction

  task automatic applyAddr(logic [23:0] ma, logic [9:0] ia, logic mc, logic ic, string tag);
    item_t it;
    @(negedge clk);
    memAddr = ma; ioAddr = ia; memCycle = mc; ioCycle = ic;
    it.rdChk = 0; it.expRd = '0;
    it.expWin = modelWin(ma, ia, mc, ic);
    it.expFast = |it.expWin;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic applyExpect(logic [23:0] ma, logic [9:0] ia, logic mc, logic ic,
                             logic [2:0] expW, string tag);
    item_t it;
    @(negedge clk);
    memAddr = ma; ioAddr = ia; memCycle = mc; ioCycle = ic;
    it.rdChk = 0; it.expRd = '0; it.expWin = expW; it.expFast = |expW; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic checkRead(int idx, logic [7:0] exp, string tag);
    item_t it;
    @(negedge clk);
    cfgIdxWr = 1'b1; cfgWdata = 8'(idx);
    @(negedge clk);
    cfgIdxWr = 1'b0;
    it.rdChk = 1; it.expRd = exp; it.expWin = '0; it.expFast = 1'b0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic writeReg(int idx, logic [7:0] val);
    @(negedge clk);
    cfgIdxWr = 1'b1; cfgWdata = 8'(idx);
    @(negedge clk);
    cfgIdxWr = 1'b0; cfgDataWr = 1'b1; cfgWdata = val;
    @(negedge clk);
    cfgDataWr = 1'b0;
    if (idx == 0) sh[0] = {7'b0, val[0]};
    else if (idx < NUM_REG) sh[idx] = val;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (it.rdChk) begin
          if (cfgRdata !== it.expRd) begin
            failures++;
            $display("FAIL %s: cfgRdata=%02h expected=%02h", it.tag, cfgRdata, it.expRd);
          end
        end else if (winHit !== it.expWin || fastHit !== it.expFast) begin
          failures++;
          $display("FAIL %s: winHit=%b fastHit=%b expected winHit=%b fastHit=%b",
                   it.tag, winHit, fastHit, it.expWin, it.expFast);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(5ns * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv [9] = '{8'h00, 8'h00, 8'hFF, 8'hF0, 8'h00, 8'hFF, 8'hF0, 8'h00, 8'hFF};
    for (int i = 0; i < 16; i++) sh[i] = (i < 9) ? rv[i] : 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values, R3 unused indices
    for (int i = 0; i < 9; i++) checkRead(i, rv[i], "R1 reset value");
    for (int i = 9; i < 16; i++) checkRead(i, 8'h00, "R3 unused index reads zero");

    // R4 disabled: no hits even on matching address
    applyExpect(24'h000000, 10'h000, 1'b1, 1'b1, 3'b000, "R4 enable clear blocks hits");

    writeReg(0, 8'hFF);
    checkRead(0, 8'h01, "R3 control upper bits zero");

    // R10 reset configuration compares against zero
    applyExpect(24'h000ABC, 10'h000, 1'b1, 1'b0, 3'b011, "R10 default mem zero page hit");
    applyExpect(24'h001000, 10'h000, 1'b1, 1'b0, 3'b000, "R10 default mem miss");
    applyExpect(24'h000000, 10'h003, 1'b0, 1'b1, 3'b100, "R10 default io low bits ignored");
    applyExpect(24'h000000, 10'h004, 1'b0, 1'b1, 3'b000, "R10 default io miss");

    // R8 strobes
    applyExpect(24'h000000, 10'h000, 1'b0, 1'b0, 3'b000, "R8 no strobe no hit");
    applyExpect(24'h000000, 10'h000, 1'b0, 1'b1, 3'b100, "R8 io strobe only");
    applyExpect(24'h000000, 10'h000, 1'b1, 1'b0, 3'b011, "R8 mem strobe only");

    // R6 / R5 explicit windows
    writeReg(1, 8'hC0); writeReg(3, 8'hF5);
    writeReg(4, 8'hA0); writeReg(5, 8'hF0); writeReg(6, 8'h00);
    checkRead(3, 8'hF5, "R2 packed register readback");
    checkRead(5, 8'hF0, "R2 mask register readback");
    applyExpect(24'hC05123, 10'h000, 1'b1, 1'b0, 3'b001, "R6 window0 exact hit");
    applyExpect(24'hC06123, 10'h000, 1'b1, 1'b0, 3'b000, "R6 window0 low nibble miss");
    applyExpect(24'hA5F000, 10'h000, 1'b1, 1'b0, 3'b010, "R5 window1 dont-care bits");
    applyExpect(24'hB00000, 10'h000, 1'b1, 1'b0, 3'b000, "R5 window1 compared nibble miss");

    // R7 io window
    writeReg(7, 8'h3C); writeReg(8, 8'hF0);
    applyExpect(24'h000000, 10'h0C7, 1'b0, 1'b1, 3'b100, "R7 io upper nibble hit");
    applyExpect(24'h000000, 10'h100, 1'b0, 1'b1, 3'b000, "R7 io miss");
    applyExpect(24'hC05000, 10'h0FF, 1'b1, 1'b1, 3'b101, "R9 two windows OR");

    // R3 write to unused index ignored
    writeReg(12, 8'h5A);
    checkRead(12, 8'h00, "R3 unused write ignored");

    // R5 R6 R7 R9 random
    for (int blk = 0; blk < 4; blk++) begin
      for (int r = 1; r < 9; r++) writeReg(r, 8'($urandom));
      for (int n = 0; n < 60; n++) begin
        logic [23:0] ma;
        logic [9:0]  ia;
        ma = 24'($urandom);
        ia = 10'($urandom);
        if (n % 2 == 0) begin
          int w;
          w = n % 4 == 0 ? 0 : 1;
          ma[23:12] = {sh[1+3*w], sh[3+3*w][3:0]} ^
                      (12'($urandom) & ~{sh[2+3*w], sh[3+3*w][7:4]});
          ia[9:2] = sh[7] ^ (8'($urandom) & ~sh[8]);
        end
        applyAddr(ma, ia, 1'($urandom), 1'($urandom), "R5/R6/R7/R9 random compare");
      end
    end

    // R4 disable again
    writeReg(0, 8'h00);
    applyExpect({sh[1], sh[3][3:0], 12'h000}, {sh[7], 2'b00}, 1'b1, 1'b1, 3'b000,
                "R4 enable cleared blocks hits");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule